// File: doc/BRIEF.md
# Channel Program Sequencer

This block is a single-channel micro-engine that drives a burst-oriented data mover from a small program held in a local instruction memory. The program sets a source pointer, a destination pointer and a control word. It can nest two counted loops, run an endless loop, shift either pointer by a 16-bit immediate, and issue load and store bursts. Each burst goes out as one request on a valid/ready command port that carries a direction, a start address, a beat count and a beat size. Moving the data itself, and the bus timing, belong to the agent that consumes the command port.

The program memory is written through a simple word write port while the channel is idle. A start pulse begins execution at a chosen word address. The engine then retires one instruction per cycle. The only exception is a load or store, which waits until the command port accepts it. The halt instruction ends the program and raises a one-cycle done pulse. The kill input aborts the channel from any state and also raises done.

Instruction word layout: opcode in bits [31:28], select in bits [27:26], immediate in bits [15:0]. Bits [25:16] are ignored. A pointer-set instruction is followed by one data word. The control word holds the source beats minus one in [3:0], the source size code in [6:4], the destination beats minus one in [11:8] and the destination size code in [14:12]. The size code is log2 of the bytes per beat, 0 to 4.

Top module: `chanprog_seq`

## Requirements
- R1: While reset is held and right after it, busy, done and cmd_valid are low.
- R2: A start pulse while idle makes busy high at the next edge and begins execution at start_pc. A start pulse while busy is ignored.
- R3: Opcode 2 (set) loads the data word that follows it into the source pointer (select 0), the destination pointer (select 1) or the control word (select 2). Execution then resumes two words later.
- R4: Opcode 6 (load) and opcode 7 (store) raise cmd_valid with cmd_write 0 or 1. The request carries the matching pointer, beats minus one and size code. It holds all of these steady until cmd_ready is high.
- R5: In the cycle a request is accepted, the matching pointer grows by (beats) << size bytes. For example, 16 beats of 64 bits add 0x80. A stalled request moves nothing.
- R6: Opcode 3 loads counter (select 0 or 1) with the immediate [7:0]. Opcode 4 jumps to the immediate word address while that counter is non-zero, decrementing it, so a body runs immediate+1 times (1 to 256). The two counters nest.
- R7: Opcode 5 always jumps to its immediate word address. The channel stays busy and never raises done until killed.
- R8: Opcode 8 adds the immediate, zero-extended, to the source pointer (select 0) or the destination pointer (select 1).
- R9: Opcode 9 adds the immediate extended with ones, so 0xFFFE subtracts 2 from the pointer.
- R10: A control word set in the middle of a program governs every later burst. Bursts before it keep their old lengths and sizes.
- R11: Kill drops cmd_valid in the same cycle and sends the channel idle at the next edge, clearing the program counter and both loop counters, with done high for that one cycle. A request offered with cmd_ready in the kill cycle is not accepted, and its pointer keeps its value.
- R12: Opcode 0 (halt) ends the program: busy goes low and done is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pm_we | input | 1 | Program memory write enable |
| pm_addr | input | PC_W | Program memory word address |
| pm_wdata | input | 32 | Program memory write data |
| start | input | 1 | Begin execution when idle |
| start_pc | input | PC_W | First instruction address |
| kill | input | 1 | Abort channel |
| busy | output | 1 | Channel executing |
| done | output | 1 | One-cycle pulse on halt or kill |
| cmd_valid | output | 1 | Burst request present |
| cmd_ready | input | 1 | Burst request accepted |
| cmd_write | output | 1 | 0 load (read), 1 store (write) |
| cmd_addr | output | ADDR_W | Burst start address |
| cmd_len_m1 | output | LEN_W | Beats minus one |
| cmd_size | output | 3 | log2 bytes per beat |

## Verification
The collision of interest is a kill that arrives in the same cycle that the command port signals ready for a pending load. The bench stalls a load with ready low and then raises kill and ready together. It judges the result in three places. cmd_valid must be low in that cycle. The channel must go idle with a single done pulse. When the same load is restarted on its own, it must present the unchanged address, which shows that the pointer never advanced.

// File: rtl/chanprog_pkg.sv
package chanprog_pkg;

    localparam int INSN_W = 32;
    localparam int IMM_W  = 16;

    // opcode values, field [31:28]
    typedef enum logic [3:0] {
        OPC_HALT  = 4'd0,
        OPC_NOP   = 4'd1,
        OPC_SET   = 4'd2,
        OPC_LOOP  = 4'd3,
        OPC_LEND  = 4'd4,
        OPC_LEVER = 4'd5,
        OPC_LOAD  = 4'd6,
        OPC_STORE = 4'd7,
        OPC_ADDP  = 4'd8,
        OPC_ADDN  = 4'd9
    } opc_e;

    typedef enum logic [2:0] {
        K_HALT, K_NOP, K_SET, K_LOOP, K_LEND, K_LEVER, K_XFER, K_ADJ
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [1:0]        sel;
        logic [IMM_W-1:0]  imm;
        logic              wr;
        logic              neg;
    } dec_t;

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    // control word field offsets
    localparam int CTL_SLEN = 0;
    localparam int CTL_SSZ  = 4;
    localparam int CTL_DLEN = 8;
    localparam int CTL_DSZ  = 12;

endpackage

// File: rtl/chanprog_imem.sv
module chanprog_imem #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata0,
    output logic [DW-1:0] rdata1
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] raddr_nx;

    assign raddr_nx = raddr + AW'(1);

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata0 = mem_q[raddr];
    assign rdata1 = mem_q[raddr_nx];
endmodule

// File: rtl/chanprog_decode.sv
module chanprog_decode
    import chanprog_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    logic unused_rsvd;
    assign unused_rsvd = ^insn[25:16];

    always_comb begin
        dec.sel  = insn[27:26];
        dec.imm  = insn[IMM_W-1:0];
        dec.wr   = 1'b0;
        dec.neg  = 1'b0;
        case (insn[31:28])
            OPC_HALT:  dec.kind = K_HALT;
            OPC_SET:   dec.kind = K_SET;
            OPC_LOOP:  dec.kind = K_LOOP;
            OPC_LEND:  dec.kind = K_LEND;
            OPC_LEVER: dec.kind = K_LEVER;
            OPC_LOAD:  dec.kind = K_XFER;
            OPC_STORE: begin dec.kind = K_XFER; dec.wr = 1'b1; end
            OPC_ADDP:  dec.kind = K_ADJ;
            OPC_ADDN:  begin dec.kind = K_ADJ; dec.neg = 1'b1; end
            default:   dec.kind = K_NOP;
        endcase
    end
endmodule

// File: rtl/chanprog_stride.sv
module chanprog_stride #(
    parameter int LEN_W  = 4,
    parameter int ADDR_W = 32
) (
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [2:0]        size,
    output logic [ADDR_W-1:0] incr
);
    logic [LEN_W:0] beats;
    assign beats = {1'b0, len_m1} + {{LEN_W{1'b0}}, 1'b1};
    assign incr  = ADDR_W'(beats) << size;
endmodule

// File: rtl/chanprog_seq.sv
module chanprog_seq
    import chanprog_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    parameter int ADDR_W     = 32,
    parameter int NUM_LC     = 2,
    parameter int CNT_W      = 8,
    parameter int LEN_W      = 4,
    localparam int PC_W      = $clog2(IMEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pm_we,
    input  logic [PC_W-1:0]   pm_addr,
    input  logic [31:0]       pm_wdata,
    input  logic              start,
    input  logic [PC_W-1:0]   start_pc,
    input  logic              kill,
    output logic              busy,
    output logic              done,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len_m1,
    output logic [2:0]        cmd_size
);
    localparam int LC_SEL_W = (NUM_LC > 1) ? $clog2(NUM_LC) : 1;

    typedef struct packed {
        logic                         busy;
        logic                         done;
        logic [PC_W-1:0]              pc;
        logic [NUM_LC-1:0][CNT_W-1:0] lc;
        logic [ADDR_W-1:0]            src;
        logic [ADDR_W-1:0]            dst;
        logic [LEN_W-1:0]             slen;
        logic [LEN_W-1:0]             dlen;
        logic [2:0]                   ssz;
        logic [2:0]                   dsz;
    } st_t;

    st_t st_q, st_d;

    logic [INSN_W-1:0] word0, word1;
    dec_t              dec;
    logic [ADDR_W-1:0] incr_v [2];
    logic [LEN_W-1:0]  len_v  [2];
    logic [2:0]        sz_v   [2];
    logic [ADDR_W-1:0] adj_ext;
    logic [LC_SEL_W-1:0] lc_idx;
    logic              xfer_now;

    chanprog_imem #(.DEPTH(IMEM_DEPTH), .AW(PC_W), .DW(INSN_W)) u_imem (
        .clk    (clk),
        .we     (pm_we),
        .waddr  (pm_addr),
        .wdata  (pm_wdata),
        .raddr  (st_q.pc),
        .rdata0 (word0),
        .rdata1 (word1)
    );

    chanprog_decode u_dec (
        .insn (word0),
        .dec  (dec)
    );

    assign len_v[0] = st_q.slen;
    assign len_v[1] = st_q.dlen;
    assign sz_v[0]  = st_q.ssz;
    assign sz_v[1]  = st_q.dsz;

    // one stride unit per direction: 0 source, 1 destination
    for (genvar g = 0; g < 2; g++) begin : g_stride
        chanprog_stride #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_stride (
            .len_m1 (len_v[g]),
            .size   (sz_v[g]),
            .incr   (incr_v[g])
        );
    end

    assign adj_ext  = {{(ADDR_W-IMM_W){dec.neg}}, dec.imm};
    assign lc_idx   = dec.sel[LC_SEL_W-1:0];
    assign xfer_now = st_q.busy && (dec.kind == K_XFER) && !kill;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (kill) begin
            st_d.busy = 1'b0;
            st_d.pc   = '0;
            st_d.lc   = '0;
            st_d.done = 1'b1;
        end else if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.pc   = start_pc;
            end
        end else begin
            case (dec.kind)
                K_HALT: begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end
                K_SET: begin
                    case (dec.sel)
                        SEL_SRC:  st_d.src = ADDR_W'(word1);
                        SEL_DST:  st_d.dst = ADDR_W'(word1);
                        SEL_CTRL: begin
                            st_d.slen = word1[CTL_SLEN +: LEN_W];
                            st_d.ssz  = word1[CTL_SSZ  +: 3];
                            st_d.dlen = word1[CTL_DLEN +: LEN_W];
                            st_d.dsz  = word1[CTL_DSZ  +: 3];
                        end
                        default: ;
                    endcase
                    st_d.pc = st_q.pc + PC_W'(2);
                end
                K_LOOP: begin
                    st_d.lc[lc_idx] = dec.imm[CNT_W-1:0];
                    st_d.pc = st_q.pc + PC_W'(1);
                end
                K_LEND: begin
                    if (st_q.lc[lc_idx] != '0) begin
                        st_d.lc[lc_idx] = st_q.lc[lc_idx] - CNT_W'(1);
                        st_d.pc = dec.imm[PC_W-1:0];
                    end else begin
                        st_d.pc = st_q.pc + PC_W'(1);
                    end
                end
                K_LEVER: st_d.pc = dec.imm[PC_W-1:0];
                K_XFER: begin
                    if (cmd_ready) begin
                        if (dec.wr) st_d.dst = st_q.dst + incr_v[1];
                        else        st_d.src = st_q.src + incr_v[0];
                        st_d.pc = st_q.pc + PC_W'(1);
                    end
                end
                K_ADJ: begin
                    if (dec.sel[0]) st_d.dst = st_q.dst + adj_ext;
                    else            st_d.src = st_q.src + adj_ext;
                    st_d.pc = st_q.pc + PC_W'(1);
                end
                default: st_d.pc = st_q.pc + PC_W'(1);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy       = st_q.busy;
    assign done       = st_q.done;
    assign cmd_valid  = xfer_now;
    assign cmd_write  = dec.wr;
    assign cmd_addr   = dec.wr ? st_q.dst  : st_q.src;
    assign cmd_len_m1 = dec.wr ? st_q.dlen : st_q.slen;
    assign cmd_size   = dec.wr ? st_q.dsz  : st_q.ssz;
endmodule

// File: rtl/chanprog_seq_chk.sv
module chanprog_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              kill,
    input logic              busy,
    input logic              done,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_write,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [LEN_W-1:0]  cmd_len_m1,
    input logic [2:0]        cmd_size
);
    a_r4_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> kill || (cmd_valid && $stable(cmd_addr) &&
        $stable(cmd_write) && $stable(cmd_len_m1) && $stable(cmd_size)));

    a_r11_kill_idle: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !busy && done);

    a_r11_kill_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        kill |-> !cmd_valid);

    a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r2_cmd_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);
endmodule

bind chanprog_seq chanprog_seq_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .kill       (kill),
    .busy       (busy),
    .done       (done),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_write  (cmd_write),
    .cmd_addr   (cmd_addr),
    .cmd_len_m1 (cmd_len_m1),
    .cmd_size   (cmd_size)
);

// File: tb/chanprog_seq_tb.sv
`timescale 1ns/1ps
module chanprog_seq_tb;
    localparam int PCW = 6;

    localparam logic [3:0] O_HALT = 4'd0, O_SET = 4'd2, O_LOOP = 4'd3,
        O_LEND = 4'd4, O_LEVER = 4'd5, O_LOAD = 4'd6, O_STORE = 4'd7,
        O_ADDP = 4'd8, O_ADDN = 4'd9;

    // {write, addr, len_m1, size}
    localparam logic [39:0] EXP1 [8] = '{
        {1'b0, 32'h0000_1000, 4'hF, 3'd3},
        {1'b1, 32'h0000_8000, 4'hF, 3'd3},
        {1'b0, 32'h0000_1080, 4'hF, 3'd3},
        {1'b1, 32'h0000_8080, 4'hF, 3'd3},
        {1'b0, 32'h0000_1100, 4'h2, 3'd0},
        {1'b1, 32'h0000_8100, 4'h2, 3'd0},
        {1'b0, 32'h0000_1101, 4'h2, 3'd0},
        {1'b1, 32'h0000_8203, 4'h2, 3'd0}
    };

    logic clk = 1'b0;
    logic rst_n, pm_we, start, kill, cmd_ready;
    logic [PCW-1:0] pm_addr, start_pc;
    logic [31:0] pm_wdata;
    logic busy, done, cmd_valid, cmd_write;
    logic [31:0] cmd_addr;
    logic [3:0] cmd_len_m1;
    logic [2:0] cmd_size;

    always #5 clk = ~clk;

    chanprog_seq u_dut (
        .clk(clk), .rst_n(rst_n), .pm_we(pm_we), .pm_addr(pm_addr),
        .pm_wdata(pm_wdata), .start(start), .start_pc(start_pc), .kill(kill),
        .busy(busy), .done(done), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len_m1(cmd_len_m1),
        .cmd_size(cmd_size)
    );

    int n_vec = 0, n_bad = 0;
    int cap_n = 0, done_cnt = 0;
    logic [39:0] cap [64];

    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (cmd_valid && cmd_ready && cap_n < 64) begin
                cap[cap_n] = {cmd_write, cmd_addr, cmd_len_m1, cmd_size};
                cap_n++;
            end
            if (done) done_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ins(input logic [3:0] op, input logic [1:0] sel,
                                        input logic [15:0] imm);
        return {op, sel, 10'd0, imm};
    endfunction

    task automatic pw(input int a, input logic [31:0] d);
        @(posedge clk); #1;
        pm_we = 1'b1; pm_addr = PCW'(a); pm_wdata = d;
        @(posedge clk); #1;
        pm_we = 1'b0;
    endtask

    task automatic go(input int pc);
        @(posedge clk); #1;
        start = 1'b1; start_pc = PCW'(pc);
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_done(input int lim);
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (done) break;
        end
    endtask

    task automatic clear_cap();
        cap_n = 0; done_cnt = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R12: actual no completion expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pm_we = 1'b0; start = 1'b0; kill = 1'b0; cmd_ready = 1'b0;
        pm_addr = '0; start_pc = '0; pm_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !cmd_valid, "R1 reset outputs",
            {busy, done, cmd_valid}, 0);

        // program 1: copy with mid-program control change and adjusts
        pw(0, ins(O_SET, 0, 0));   pw(1, 32'h1000);
        pw(2, ins(O_SET, 1, 0));   pw(3, 32'h8000);
        pw(4, ins(O_SET, 2, 0));   pw(5, 32'h3F3F);
        pw(6, ins(O_LOOP, 0, 1));
        pw(7, ins(O_LOAD, 0, 0));  pw(8, ins(O_STORE, 0, 0));
        pw(9, ins(O_LEND, 0, 7));
        pw(10, ins(O_SET, 2, 0));  pw(11, 32'h0202);
        pw(12, ins(O_LOAD, 0, 0)); pw(13, ins(O_STORE, 0, 0));
        pw(14, ins(O_ADDN, 0, 16'hFFFE));
        pw(15, ins(O_ADDP, 1, 16'h0100));
        pw(16, ins(O_LOAD, 0, 0)); pw(17, ins(O_STORE, 0, 0));
        pw(18, ins(O_HALT, 0, 0));
        // program 2: nested loops
        pw(32, ins(O_SET, 2, 0));  pw(33, 32'h0);
        pw(34, ins(O_SET, 0, 0));  pw(35, 32'h0);
        pw(36, ins(O_LOOP, 0, 2)); pw(37, ins(O_LOOP, 1, 1));
        pw(38, ins(O_LOAD, 0, 0)); pw(39, ins(O_LEND, 1, 38));
        pw(40, ins(O_ADDP, 0, 16'h10)); pw(41, ins(O_LEND, 0, 37));
        pw(42, ins(O_HALT, 0, 0));
        // program 3: stall and kill
        pw(48, ins(O_SET, 0, 0));  pw(49, 32'h2000);
        pw(50, ins(O_SET, 2, 0));  pw(51, 32'h0023);
        pw(52, ins(O_LOAD, 0, 0)); pw(53, ins(O_LOAD, 0, 0));
        pw(54, ins(O_HALT, 0, 0));
        // program 4: endless loop
        pw(56, ins(O_LOAD, 0, 0)); pw(57, ins(O_LEVER, 0, 56));
        pw(58, ins(O_HALT, 0, 0));

        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R1 after reset", {busy, done}, 0);

        // table walk: R3 R4 R5 R6 R8 R9 R10
        clear_cap(); cmd_ready = 1'b1;
        go(0);
        wait_done(300);
        @(negedge clk);
        chk(cap_n == 8, "R4 burst count", 64'(cap_n), 8);
        for (int i = 0; i < 8; i++)
            chk(cap[i] === EXP1[i], $sformatf("R3/R5/R8/R9/R10 vector %0d", i),
                64'(cap[i]), 64'(EXP1[i]));
        chk(done_cnt == 1 && !busy, "R12 single done pulse, idle",
            64'(done_cnt), 1);

        // R6 nested loops
        clear_cap();
        go(32);
        wait_done(300);
        @(negedge clk);
        chk(cap_n == 6, "R6 nested iterations", 64'(cap_n), 6);
        for (int o = 0; o < 3; o++)
            for (int i = 0; i < 2; i++)
                chk(cap[o*2+i][38:7] == 32'(o*18 + i), "R6 nested address",
                    64'(cap[o*2+i][38:7]), 64'(o*18 + i));

        // R4 stall, R2 start ignored while busy
        clear_cap(); cmd_ready = 1'b0;
        go(48);
        repeat (6) @(negedge clk);
        chk(cmd_valid && !cmd_write && cmd_addr == 32'h2000 && cmd_len_m1 == 4'd3 &&
            cmd_size == 3'd2, "R4 stalled request",
            {cmd_valid, cmd_write, cmd_addr, cmd_len_m1, cmd_size},
            {1'b1, 1'b0, 32'h2000, 4'd3, 3'd2});
        go(0);
        @(negedge clk);
        chk(cmd_valid && cmd_addr == 32'h2000, "R2 start while busy ignored",
            64'(cmd_addr), 64'h2000);
        @(posedge clk); #1; cmd_ready = 1'b1;
        @(posedge clk); #1; cmd_ready = 1'b0;
        @(negedge clk);
        chk(cap_n == 1 && cmd_valid && cmd_addr == 32'h2010, "R5 advance after accept",
            64'(cmd_addr), 64'h2010);
        // R11 kill and ready in the same cycle
        @(posedge clk); #1; kill = 1'b1; cmd_ready = 1'b1;
        @(negedge clk);
        chk(!cmd_valid, "R11 no request in kill cycle", 64'(cmd_valid), 0);
        @(posedge clk); #1; kill = 1'b0; cmd_ready = 1'b0;
        @(negedge clk);
        chk(!busy && done, "R11 idle with done", {busy, done}, 1);
        @(negedge clk);
        chk(!done && cap_n == 1, "R11 done one cycle, no accept",
            {done, 8'(cap_n)}, 1);
        cmd_ready = 1'b1;
        go(53);
        wait_done(50);
        @(negedge clk);
        chk(cap_n == 2 && cap[1][38:7] == 32'h2010, "R11 pointer unchanged by kill",
            64'(cap[1][38:7]), 64'h2010);

        // R7 endless loop
        clear_cap();
        go(56);
        repeat (20) @(negedge clk);
        chk(busy && done_cnt == 0, "R7 still running", {busy, 8'(done_cnt)}, 64'h100);
        chk(cap_n >= 9, "R7 repeated bursts", 64'(cap_n), 9);
        @(posedge clk); #1; kill = 1'b1;
        @(posedge clk); #1; kill = 1'b0;
        @(negedge clk);
        chk(!busy, "R11 kill stops endless loop", 64'(busy), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule